// File: doc/BRIEF.md
# BCD Real-Time Clock with Snapshot and Base-Time Holding Registers

This block keeps calendar time in binary-coded decimal: seconds, minutes, hours (24-hour form), day of week, day of month, month, two-digit year and a century count. Calendar rules are built in: months are 28, 29, 30 or 31 days long, leap years are applied, and the count rolls over at the end of a year and at the end of a century. A 1 Hz strobe drives the count. A parameter can instead place a divider in front of it, so that a faster enable can be used.

A host reaches the clock through a 16-byte register window. The window sits at the top of a byte-addressed space and is accessed with chip-select, write-enable, address and data. A set of user-visible holding registers sits between the running counters and the host. Normally the holding registers follow the counters. A freeze bit lets the host read a consistent snapshot while the counters keep going. A hold bit lets the host compose a new base time in the holding registers; clearing that bit loads the base time into the counters. A stop bit halts the oscillator. A sticky fault flag records an oscillator failure reported from outside.

Top module: `bcd_rtc`

## Requirements
- R1: After reset, the time registers read second 00, minute 00, hour 00, weekday 01, date 01, month 01, year 00 and century 20. The flags and control registers read 00.
- R2: The window is the 16 addresses whose upper address bits are all ones. Offsets are: 0 flags, 1 second, 2 minute, 3 hour, 4 weekday, 5 date, 6 month, 7 year, 8 control, 9 century. Read data is registered and appears one cycle after the read. Reads outside the window, and of offsets 10 to 15, return 00. Writes outside the window have no effect. Bits with no function read 0: second and minute have 7 bits, hour and date 6, month 5, weekday 3, and of the control register only bit 7 is used.
- R3: Flags bit 0 is the freeze bit. While it is 1, the holding registers keep their value and the counters keep advancing. One tick period after the host writes it to 0, every holding register shows the current count.
- R4: Flags bit 1 is the hold bit. While it is 1, host writes to offsets 1 to 7 and 9 change the holding registers. While it is 0, those writes are ignored. When the host writes 0 over a 1, the counters take the held values on the next clock edge, and counting continues from there.
- R5: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00, and a BCD digit carry takes 09 to 10.
- R6: Each midnight advances the weekday from 1 through 7 and back to 1, and advances the date.
- R7: April, June, September and November end after day 30. The other months, except February, end after day 31.
- R8: February ends after day 29 in a leap year and after day 28 otherwise. A year is a leap year when it is divisible by 4. A year 00 is a leap year only when the century is divisible by 4.
- R9: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and increments the century. Century 99 wraps to 00.
- R10: Control bit 7 is the stop bit, which resets to 0. While it is 1, incoming ticks are ignored and the count does not move.
- R11: A pulse on osc_fault sets flags bit 2, which stays set until the host writes flags with bit 2 at 0. If a pulse and such a write arrive in the same cycle, the pulse wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | One-cycle strobe per second, or the divider's input enable |
| osc_fault | input | 1 | Oscillator failure report, sets the sticky flag |
| cs | input | 1 | Bus chip select |
| we | input | 1 | Bus write enable (1 write, 0 read) |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The bench sets base times just before each calendar boundary and ticks across it. The boundaries are the digit carry at 09, midnight, the ends of 30- and 31-day months, February in ordinary years, in leap years, in century non-leap years and in a divisible-by-400 year, and the year and century rollovers. A design with a wrong month table or wrong leap rule would land on the wrong date or month, for example 02-29 in 2100. The bench ticks while the freeze bit, the hold bit or the stop bit is set. A design that let the snapshot drift, kept the ticks that arrived during hold, or counted while stopped would show a changed seconds value. Masked bits, addresses outside the window and writes made while the hold bit is clear are also probed; a design that leaked any of these would read back nonzero or changed data.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hr;
    logic [6:0] mins;
    logic [6:0] sec;
  } rtc_time_t;

  localparam logic [3:0] OFS_FLAGS = 4'd0;
  localparam logic [3:0] OFS_SEC   = 4'd1;
  localparam logic [3:0] OFS_MIN   = 4'd2;
  localparam logic [3:0] OFS_HR    = 4'd3;
  localparam logic [3:0] OFS_DOW   = 4'd4;
  localparam logic [3:0] OFS_DATE  = 4'd5;
  localparam logic [3:0] OFS_MON   = 4'd6;
  localparam logic [3:0] OFS_YR    = 4'd7;
  localparam logic [3:0] OFS_CTRL  = 4'd8;
  localparam logic [3:0] OFS_CEN   = 4'd9;

  localparam int FLG_FRZ  = 0;
  localparam int FLG_HOLD = 1;
  localparam int FLG_FAIL = 2;
  localparam int CTL_STOP = 7;

  localparam rtc_time_t TIME_RST = '{cen: 8'h20, yr: 8'h00, mon: 5'h01,
                                     date: 6'h01, dow: 3'd1, hr: 6'h00,
                                     mins: 7'h00, sec: 7'h00};

  // Add one to a two-digit BCD value (caller handles the upper wrap).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  function automatic logic [6:0] bcd_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cen);
    logic [6:0] y;
    logic [6:0] c;
    y = bcd_bin(yr);
    c = bcd_bin(cen);
    if (y != 7'd0) return (y[1:0] == 2'd0);
    else           return (c[1:0] == 2'd0);
  endfunction

  function automatic logic [5:0] month_days(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter bit USE_DIV = 1'b0,
  parameter int DIV     = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  input  logic stop,
  output logic tick_o
);
  logic tick_raw;

  generate
    if (USE_DIV) begin : g_div
      localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || stop) cnt <= '0;
        else if (tick_in) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
      assign tick_raw = tick_in && (cnt == LAST);
    end else begin : g_direct
      assign tick_raw = tick_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= tick_raw && !stop;
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core import rtc_pkg::*; (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t live
);
  rtc_time_t  nxt;
  logic       leap;
  logic [5:0] mdays;
  logic       cy_s, cy_m, cy_h, cy_d, cy_mo, cy_y;

  always_comb begin
    leap  = is_leap(live.yr, live.cen);
    mdays = month_days(live.mon, leap);
    cy_s  = (live.sec == 7'h59);
    cy_m  = cy_s && (live.mins == 7'h59);
    cy_h  = cy_m && (live.hr == 6'h23);
    cy_d  = cy_h && (live.date >= mdays);
    cy_mo = cy_d && (live.mon >= 5'h12);
    cy_y  = cy_mo && (live.yr == 8'h99);

    nxt      = live;
    nxt.sec  = cy_s ? 7'h00 : 7'(bcd_inc(8'(live.sec)));
    if (cy_s)  nxt.mins = cy_m ? 7'h00 : 7'(bcd_inc(8'(live.mins)));
    if (cy_m)  nxt.hr   = cy_h ? 6'h00 : 6'(bcd_inc(8'(live.hr)));
    if (cy_h) begin
      nxt.dow  = (live.dow >= 3'd7) ? 3'd1 : live.dow + 3'd1;
      nxt.date = cy_d ? 6'h01 : 6'(bcd_inc(8'(live.date)));
    end
    if (cy_d)  nxt.mon  = cy_mo ? 5'h01 : 5'(bcd_inc(8'(live.mon)));
    if (cy_mo) nxt.yr   = cy_y ? 8'h00 : bcd_inc(live.yr);
    if (cy_y)  nxt.cen  = (live.cen == 8'h99) ? 8'h00 : bcd_inc(live.cen);
  end

  always_ff @(posedge clk) begin
    if (rst)       live <= TIME_RST;
    else if (load) live <= load_val;
    else if (tick) live <= nxt;
  end
endmodule

// File: rtl/rtc_hostregs.sv
module rtc_hostregs import rtc_pkg::*; #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              osc_fault,
  input  rtc_time_t         live,
  output logic [7:0]        rdata,
  output rtc_time_t         usr,
  output logic              load_o,
  output logic              stop_o
);
  logic       hit, wr, rd;
  logic [3:0] ofs;
  logic       frz, hold, fail;
  logic [7:0] rd_mux;

  assign hit = &addr[ADDR_W-1:4];
  assign ofs = addr[3:0];
  assign wr  = cs && we && hit;
  assign rd  = cs && !we;

  always_comb begin
    case (ofs)
      OFS_FLAGS: rd_mux = {5'b0, fail, hold, frz};
      OFS_SEC:   rd_mux = {1'b0, usr.sec};
      OFS_MIN:   rd_mux = {1'b0, usr.mins};
      OFS_HR:    rd_mux = {2'b0, usr.hr};
      OFS_DOW:   rd_mux = {5'b0, usr.dow};
      OFS_DATE:  rd_mux = {2'b0, usr.date};
      OFS_MON:   rd_mux = {3'b0, usr.mon};
      OFS_YR:    rd_mux = usr.yr;
      OFS_CTRL:  rd_mux = {stop_o, 7'b0};
      OFS_CEN:   rd_mux = usr.cen;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frz    <= 1'b0;
      hold   <= 1'b0;
      fail   <= 1'b0;
      stop_o <= 1'b0;
      load_o <= 1'b0;
      usr    <= TIME_RST;
      rdata  <= 8'h00;
    end else begin
      load_o <= wr && (ofs == OFS_FLAGS) && hold && !wdata[FLG_HOLD];
      if (wr && ofs == OFS_FLAGS) begin
        frz  <= wdata[FLG_FRZ];
        hold <= wdata[FLG_HOLD];
      end
      if (osc_fault) fail <= 1'b1;
      else if (wr && ofs == OFS_FLAGS && !wdata[FLG_FAIL]) fail <= 1'b0;
      if (wr && ofs == OFS_CTRL) stop_o <= wdata[CTL_STOP];

      if (hold) begin
        if (wr) begin
          case (ofs)
            OFS_SEC:  usr.sec  <= wdata[6:0];
            OFS_MIN:  usr.mins <= wdata[6:0];
            OFS_HR:   usr.hr   <= wdata[5:0];
            OFS_DOW:  usr.dow  <= wdata[2:0];
            OFS_DATE: usr.date <= wdata[5:0];
            OFS_MON:  usr.mon  <= wdata[4:0];
            OFS_YR:   usr.yr   <= wdata;
            OFS_CEN:  usr.cen  <= wdata;
            default: ;
          endcase
        end
      end else if (!frz && !load_o) begin
        usr <= live;
      end

      if (rd) rdata <= hit ? rd_mux : 8'h00;
    end
  end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc import rtc_pkg::*; #(
  parameter int ADDR_W  = 19,
  parameter bit USE_DIV = 1'b0,
  parameter int DIV     = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              osc_fault,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic      tick, load, stop;
  rtc_time_t live, usr;

  rtc_tick_gen #(.USE_DIV(USE_DIV), .DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_in(tick_in), .stop(stop), .tick_o(tick)
  );

  rtc_core u_core (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .load_val(usr), .live(live)
  );

  rtc_hostregs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .osc_fault(osc_fault), .live(live), .rdata(rdata), .usr(usr),
    .load_o(load), .stop_o(stop)
  );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker import rtc_pkg::*; #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic              wbit_frz,
  input logic [7:0]        rdata,
  input logic              osc_fault,
  input logic              tick,
  input logic              load,
  input logic              stop,
  input rtc_time_t         live,
  input rtc_time_t         usr
);
  logic hit, frz_sh;
  assign hit = &addr[ADDR_W-1:4];

  always_ff @(posedge clk) begin
    if (rst) frz_sh <= 1'b0;
    else if (cs && we && hit && addr[3:0] == OFS_FLAGS) frz_sh <= wbit_frz;
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && live.sec == 7'h59) |=> (live.sec == 7'h00)); // R5
  AST_SNAPSHOT_STILL: assert property (@(posedge clk) disable iff (rst)
    (frz_sh && !(cs && we)) |=> $stable(usr)); // R3
  AST_BASE_LOADED: assert property (@(posedge clk) disable iff (rst)
    load |=> (live == $past(usr))); // R4
  AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (stop && $past(stop) && !load) |=> $stable(live)); // R10
  AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && !hit) |=> (rdata == 8'h00)); // R2
  AST_FAULT_STICKS: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && hit && addr[3:0] == OFS_FLAGS && $past(osc_fault)) |=> rdata[FLG_FAIL]); // R11
endmodule

bind bcd_rtc rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wbit_frz(wdata[0]),
  .rdata(rdata), .osc_fault(osc_fault), .tick(tick), .load(load),
  .stop(stop), .live(live), .usr(usr)
);

// File: tb/tb_bcd_rtc.sv
module tb_bcd_rtc;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_in = 1'b0;
  logic          osc_fault = 1'b0;
  logic          cs = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = 8'h00;
  logic [7:0]    rdata;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  bcd_rtc #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .osc_fault(osc_fault),
    .cs(cs), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // Monitor: a read sampled at this edge yields rdata just after it.
  always @(posedge clk) begin
    if (!rst && cs && !we) begin
      #2;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read, got %h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: got %h expected %h", t, rdata, e);
        end
      end
    end
  end

  function automatic logic [AW-1:0] win(input logic [3:0] o);
    return {{(AW-4){1'b1}}, o};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_raw(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] o, input logic [7:0] d);
    wr_raw(win(o), d);
  endtask

  task automatic rd_raw(input logic [AW-1:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic rd(input logic [3:0] o, input logic [7:0] e, input string t);
    rd_raw(win(o), e, t);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
      idle(3);
    end
  endtask

  task automatic set_time(input logic [7:0] cen, yr, mon, date, dow, hr, mn, sc);
    wr(4'd0, 8'h02);
    wr(4'd9, cen); wr(4'd7, yr); wr(4'd6, mon); wr(4'd5, date);
    wr(4'd4, dow); wr(4'd3, hr); wr(4'd2, mn);  wr(4'd1, sc);
    wr(4'd0, 8'h00);
    idle(4);
  endtask

  task automatic date_is(input logic [7:0] mon, date, input string t);
    rd(4'd6, mon, t);
    rd(4'd5, date, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);

    // R1 reset values
    rd(4'd0, 8'h00, "R1 flags"); rd(4'd1, 8'h00, "R1 sec");
    rd(4'd2, 8'h00, "R1 min");   rd(4'd3, 8'h00, "R1 hour");
    rd(4'd4, 8'h01, "R1 dow");   rd(4'd5, 8'h01, "R1 date");
    rd(4'd6, 8'h01, "R1 month"); rd(4'd7, 8'h00, "R1 year");
    rd(4'd8, 8'h00, "R1 ctrl");  rd(4'd9, 8'h20, "R1 century");

    // R2 decode, masking, outside window
    rd(4'd12, 8'h00, "R2 spare offset");
    rd_raw('0, 8'h00, "R2 outside read");
    wr_raw(19'h00008, 8'h80);
    rd(4'd8, 8'h00, "R2 outside write ignored");
    wr(4'd8, 8'h7F);
    rd(4'd8, 8'h00, "R2 ctrl unused bits");

    // R4 time writes ignored while hold bit clear
    wr(4'd1, 8'h33);
    idle(2);
    rd(4'd1, 8'h00, "R4 write without hold");

    // R2 masked weekday via hold path
    set_time(8'h20, 8'h00, 8'h01, 8'h01, 8'hFF, 8'h00, 8'h00, 8'h00);
    rd(4'd4, 8'h07, "R2 dow width");

    // R9 year end, century 19 -> 20, plus R6 weekday wrap
    set_time(8'h19, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
    rd(4'd1, 8'h58, "R4 base loaded");
    ticks(1);
    rd(4'd1, 8'h59, "R5 sec step");
    ticks(1);
    rd(4'd1, 8'h00, "R5 sec wrap"); rd(4'd2, 8'h00, "R5 min wrap");
    rd(4'd3, 8'h00, "R5 hour wrap"); rd(4'd4, 8'h01, "R6 dow 7 to 1");
    date_is(8'h01, 8'h01, "R9 new year");
    rd(4'd7, 8'h00, "R9 year wrap"); rd(4'd9, 8'h20, "R9 century inc");

    // R9 century 99 -> 00
    set_time(8'h99, 8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    ticks(1);
    rd(4'd9, 8'h00, "R9 century wrap"); rd(4'd4, 8'h03, "R6 dow step");

    // R5 digit carry, no midnight
    set_time(8'h20, 8'h24, 8'h03, 8'h05, 8'h03, 8'h09, 8'h59, 8'h59);
    ticks(1);
    rd(4'd3, 8'h10, "R5 hour digit carry");
    rd(4'd4, 8'h03, "R6 dow unchanged midday");
    rd(4'd5, 8'h05, "R6 date unchanged midday");

    // R8 leap rule
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);  date_is(8'h02, 8'h29, "R8 2024 leap");
    ticks(86400 / 86400);  // midnight already passed; next step is a second
    set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);  date_is(8'h03, 8'h01, "R8 leap feb end");
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);  date_is(8'h03, 8'h01, "R8 2023 common");
    set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);  date_is(8'h03, 8'h01, "R8 2100 not leap");
    set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);  date_is(8'h02, 8'h29, "R8 2000 leap");

    // R7 month lengths
    set_time(8'h20, 8'h25, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);  date_is(8'h05, 8'h01, "R7 april end");
    set_time(8'h20, 8'h25, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);  date_is(8'h01, 8'h31, "R7 january day 31");
    set_time(8'h20, 8'h25, 8'h09, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);  date_is(8'h10, 8'h01, "R7 september end");

    // R3 freeze
    set_time(8'h20, 8'h25, 8'h06, 8'h10, 8'h02, 8'h12, 8'h00, 8'h00);
    wr(4'd0, 8'h01);
    idle(2);
    ticks(3);
    rd(4'd1, 8'h00, "R3 frozen sec");
    rd(4'd0, 8'h01, "R3 flags show freeze");
    wr(4'd0, 8'h00);
    idle(2);
    rd(4'd1, 8'h03, "R3 refresh after unfreeze");

    // R4 hold: ticks during hold are replaced by the base time
    wr(4'd0, 8'h02);
    ticks(2);
    wr(4'd1, 8'h40);
    rd(4'd1, 8'h40, "R4 held value");
    rd(4'd0, 8'h02, "R4 flags show hold");
    wr(4'd0, 8'h00);
    idle(4);
    rd(4'd1, 8'h40, "R4 load on release");
    ticks(1);
    rd(4'd1, 8'h41, "R4 counting resumes");

    // R10 oscillator stop
    wr(4'd8, 8'h80);
    rd(4'd8, 8'h80, "R10 stop bit reads");
    ticks(3);
    rd(4'd1, 8'h41, "R10 ticks ignored");
    wr(4'd8, 8'h00);
    ticks(1);
    rd(4'd1, 8'h42, "R10 restart");

    // R11 sticky failure flag
    @(negedge clk); osc_fault = 1'b1;
    @(negedge clk); osc_fault = 1'b0;
    idle(3);
    rd(4'd0, 8'h04, "R11 flag set");
    wr(4'd0, 8'h04);
    rd(4'd0, 8'h04, "R11 flag kept");
    wr(4'd0, 8'h00);
    rd(4'd0, 8'h00, "R11 flag cleared");

    idle(5);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule